// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This controller collects twenty-six single-cycle event pulses from peripheral blocks and folds them into one interrupt request toward a processor core. Each source owns a pending bit and an enable (mask) bit. While at least one enabled source is pending and outranks every source currently being serviced, the request is driven on one of eight level lines, chosen by software.

Sources are ranked in a fixed descending order that software can reshape in two ways. One chosen source can be lifted above all others. The five channel sources (one USB source and four serial channels) can either sit together as a block or be spread out through the order, and the four serial channels can be rotated within their slots. To acknowledge, software writes 1 to the acknowledge bit of the vector register. One cycle later the register holds the 5-bit vector of the winning source, or 0 if nothing was eligible, and the acknowledge bit has cleared itself. The acknowledged source is marked in service, and this marking gives a fully nested scheme. Source 1 is the single entry through which DMA bus errors are reported.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset every register reads 0 and `irq_lines` is 0.
- R2: `irq_lines` is one-hot at bit `level` (CFG[2:0]) exactly when some source is pending, enabled (MASK, address 2) and ranked above every in-service source; otherwise it is 0.
- R3: A pulse on `src_pulse[i]` sets PEND[i] (address 1). Writing 1 to a PEND bit clears it. A pulse and a clear of the same bit in the same cycle leave the bit set.
- R4: Writing VECT (address 4) with bit 0 = 1 makes bit 0 read 1 for exactly one cycle. It then reads 0, and VECT[8:4] holds the latched vector.
- R5: With CFG = level only (grouped, rotation 0, no promotion), rank equals source index: 0 is highest and 25 is lowest. The vector is the source index plus 1.
- R6: With CFG[3] = 1, the source numbered CFG[8:4] ranks above all others. An index above 25 promotes nothing.
- R7: Grouped scheme (CFG[9] = 0): ranks 0–3 are sources 0–3, and rank 4 is the USB source (4). Serial channel j (source 5+j) takes rank 5+((j−rot) mod 4), where rot = CFG[11:10]. Sources 9–25 keep their index as rank.
- R8: Spread scheme (CFG[9] = 1): the USB source takes rank 4, and serial slot k (k = 1..4) takes rank 4+5k. The other sources fill the remaining ranks in index order.
- R9: On acknowledge, INSV (address 3) sets the bit of the latched source. While a source is in service, sources of equal or lower rank cannot raise a request or win an acknowledge.
- R10: Writing 1 to an INSV bit clears it, and lower-ranked pending sources can then request again.
- R11: An acknowledge with no eligible source latches vector 0 and leaves INSV unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 26 | One-cycle event pulse per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 CFG, 1 PEND, 2 MASK, 3 INSV, 4 VECT) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_lines | output | 8 | Request, one-hot at the configured level |

## Verification
The order is tested by setting all 26 pending bits and draining them one acknowledge at a time. This is done under both schemes, all four rotations, and a promotion of every source in turn. The drained vector sequence must match ranks computed by closed-form arithmetic, so any misplaced slot shows up as a wrong vector at a specific step. Separate directed patterns cover the following cases: a single pending source under every level value, which separates level decoding from arbitration; a masked pending source; an acknowledge with nothing eligible; a pulse and a clear of the same bit in one cycle; and a nested sequence of higher, equal and lower arrivals around an in-service source.

// File: rtl/intc_pkg.sv
package intc_pkg;

    parameter int NSRC      = 26;
    parameter int SRC_W     = 5;
    parameter int LVL_W     = 3;
    parameter int NLVL      = 1 << LVL_W;
    parameter int ADDR_W    = 3;
    parameter int DATA_W    = 32;
    parameter int RANK_W    = $clog2(NSRC) + 1;
    parameter int CH_BASE   = 4;
    parameter int NSER      = 4;
    parameter int NCH       = NSER + 1;
    parameter int SPREAD_ST = 5;
    parameter int ROT_W     = 2;

    typedef logic [NSRC-1:0] srcvec_t;
    typedef logic [RANK_W-1:0] rank_t;
    typedef logic [NSRC-1:0][RANK_W-1:0] rank_tab_t;

    typedef enum logic [ADDR_W-1:0] {
        A_CFG  = 3'd0,
        A_PEND = 3'd1,
        A_MASK = 3'd2,
        A_INSV = 3'd3,
        A_VECT = 3'd4
    } addr_e;

    typedef struct packed {
        logic [ROT_W-1:0] rot;
        logic             spread;
        logic [SRC_W-1:0] top_src;
        logic             top_en;
        logic [LVL_W-1:0] level;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef struct packed {
        logic             found;
        logic [SRC_W-1:0] src;
    } pick_t;

    // Rank of every source for the chosen channel scheme and rotation.
    function automatic rank_tab_t build_ranks(input logic spread, input logic [ROT_W-1:0] rot);
        rank_tab_t t;
        int nc;
        int k;
        int src;
        logic ch;
        t  = '0;
        nc = 0;
        k  = 0;
        for (int r = 0; r < NSRC; r++) begin
            if (spread)
                ch = (r >= CH_BASE) && (((r - CH_BASE) % SPREAD_ST) == 0) && (k < NCH);
            else
                ch = (r >= CH_BASE) && (r < CH_BASE + NCH);
            if (ch) begin
                if (k == 0) src = CH_BASE;
                else        src = CH_BASE + 1 + ((k - 1 + int'(rot)) % NSER);
                k++;
            end else begin
                src = (nc < CH_BASE) ? nc : nc + NCH;
                nc++;
            end
            t[src] = RANK_W'(r);
        end
        return t;
    endfunction

endpackage

// File: rtl/intc_resolver.sv
module intc_resolver
    import intc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  cfg_t                cfg,
    input  srcvec_t             pend,
    input  srcvec_t             mask,
    input  srcvec_t             insv,
    output pick_t               pick,
    output logic [NLVL-1:0]     irq_lines
);

    rank_tab_t base;
    rank_t     eff [NSRC];
    rank_t     ceiling;
    srcvec_t   elig;

    assign base = build_ranks(cfg.spread, cfg.rot);

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_eff
            assign eff[i] = (cfg.top_en && (cfg.top_src == SRC_W'(i)))
                            ? '0 : base[i] + rank_t'(1);
        end
    endgenerate

    // Highest-ranked source currently in service sets the ceiling.
    always_comb begin
        ceiling = '1;
        for (int i = 0; i < NSRC; i++)
            if (insv[i] && (eff[i] < ceiling)) ceiling = eff[i];
    end

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_elig
            assign elig[i] = pend[i] && mask[i] && (eff[i] < ceiling);
        end
    endgenerate

    always_comb begin
        rank_t best;
        best = '1;
        pick = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (eff[i] < best)) begin
                best       = eff[i];
                pick.found = 1'b1;
                pick.src   = SRC_W'(i);
            end
        end
    end

    assign irq_lines = pick.found ? (NLVL'(1) << cfg.level) : '0;

    // R2
    req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_lines));

    // R2
    winner_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        pick.found |-> (pend[pick.src] && mask[pick.src]));

    // R9
    winner_not_in_service_chk: assert property (@(posedge clk) disable iff (rst)
        pick.found |-> !insv[pick.src]);

endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  srcvec_t            src_pulse,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  pick_t              pick,
    output cfg_t               cfg,
    output srcvec_t            pend,
    output srcvec_t            mask,
    output srcvec_t            insv,
    output logic [DATA_W-1:0]  rdata
);

    logic             ack_q;
    logic [SRC_W-1:0] vect_q;
    srcvec_t          pend_clr;
    srcvec_t          insv_clr;
    srcvec_t          insv_set;
    logic             unused_bits;

    assign unused_bits = &{1'b0, wdata[DATA_W-1:NSRC]};

    assign pend_clr = (we && addr == A_PEND) ? wdata[NSRC-1:0] : '0;
    assign insv_clr = (we && addr == A_INSV) ? wdata[NSRC-1:0] : '0;
    assign insv_set = (ack_q && pick.found) ? (srcvec_t'(1) << pick.src) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            mask   <= '0;
            pend   <= '0;
            insv   <= '0;
            ack_q  <= 1'b0;
            vect_q <= '0;
        end else begin
            if (we && addr == A_CFG)  cfg  <= cfg_t'(wdata[CFG_W-1:0]);
            if (we && addr == A_MASK) mask <= wdata[NSRC-1:0];
            pend <= (pend & ~pend_clr) | src_pulse;
            insv <= (insv & ~insv_clr) | insv_set;
            if (ack_q) begin
                ack_q  <= 1'b0;
                vect_q <= pick.found ? pick.src + SRC_W'(1) : '0;
            end else if (we && addr == A_VECT && wdata[0]) begin
                ack_q  <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG:   rdata[CFG_W-1:0] = cfg;
            A_PEND:  rdata[NSRC-1:0]  = pend;
            A_MASK:  rdata[NSRC-1:0]  = mask;
            A_INSV:  rdata[NSRC-1:0]  = insv;
            A_VECT:  rdata[SRC_W+3:0] = {vect_q, 3'b000, ack_q};
            default: rdata = '0;
        endcase
    end

    // R4
    ack_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
        ack_q |=> !ack_q);

    // R3
    pulse_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (|src_pulse) |=> ((pend & $past(src_pulse)) == $past(src_pulse)));

    // R11
    empty_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_q && !pick.found) |=> (vect_q == '0));

    // R9
    ack_marks_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_q && pick.found) |=> insv[$past(pick.src)]);

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import intc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NSRC-1:0]       src_pulse,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [NLVL-1:0]       irq_lines
);

    cfg_t    cfg;
    srcvec_t pend;
    srcvec_t mask;
    srcvec_t insv;
    pick_t   pick;

    intc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .src_pulse (src_pulse),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .pick      (pick),
        .cfg       (cfg),
        .pend      (pend),
        .mask      (mask),
        .insv      (insv),
        .rdata     (reg_rdata)
    );

    intc_resolver u_res (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .pend      (pend),
        .mask      (mask),
        .insv      (insv),
        .pick      (pick),
        .irq_lines (irq_lines)
    );

    // R2
    req_needs_source_chk: assert property (@(posedge clk) disable iff (rst)
        (|irq_lines) |-> ((pend & mask) != '0));

endmodule

// File: tb/tb_prio_vec_intc.sv
`timescale 1ns/1ps
module tb_prio_vec_intc;

    localparam int N = 26;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] src_pulse = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_lines;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    prio_vec_intc dut (
        .clk(clk), .rst(rst), .src_pulse(src_pulse), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_lines(irq_lines)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [N-1:0] p);
        @(negedge clk);
        src_pulse = p;
        @(negedge clk);
        src_pulse = '0;
    endtask

    // Acknowledge and return VECT as seen once the ack bit has cleared.
    task automatic ack(output logic [31:0] v);
        wr(3'd4, 32'h1);
        @(negedge clk);
        rd(3'd4, v);
    endtask

    function automatic int rank_of(input int s, input bit spread, input int rot);
        int j;
        if (s == 4) return 4;
        if (s >= 5 && s <= 8) begin
            j = ((s - 5) - rot + 4) % 4;
            return spread ? 4 + 5 * (j + 1) : 5 + j;
        end
        if (!spread) return s;
        j = (s < 4) ? s : s - 5;
        if (j < 4) return j;
        return j + 1 + (j - 4) / 4;
    endfunction

    function automatic int eff_of(input int s, input bit spread, input int rot,
                                  input bit ten, input int tsrc);
        if (ten && s == tsrc) return 0;
        return rank_of(s, spread, rot) + 1;
    endfunction

    // Drain all sources one acknowledge at a time and compare with the computed order.
    task automatic drain(input bit spread, input int rot, input bit ten, input int tsrc, input string req);
        logic [N-1:0] left;
        logic [31:0] v;
        logic [31:0] iv;
        int best;
        int bs;
        wr(3'd0, 32'(spread) << 9 | 32'(rot) << 10 | 32'(ten) << 3 | 32'(tsrc) << 4);
        wr(3'd2, {6'd0, {N{1'b1}}});
        pulse({N{1'b1}});
        left = {N{1'b1}};
        for (int n = 0; n < N; n++) begin
            best = 1000; bs = 0;
            for (int s = 0; s < N; s++)
                if (left[s] && eff_of(s, spread, rot, ten, tsrc) < best) begin
                    best = eff_of(s, spread, rot, ten, tsrc); bs = s;
                end
            ack(v);
            check(req, {27'd0, v[8:4]}, 32'(bs + 1));
            rd(3'd3, iv);
            check("R9", iv, 32'(1) << bs);
            left[bs] = 1'b0;
            wr(3'd1, 32'(1) << bs);
            wr(3'd3, 32'(1) << bs);
        end
        rd(3'd1, v);
        check(req, v, 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R1", v, 32'd0);
        end
        check("R1", {24'd0, irq_lines}, 32'd0);

        // R11 empty acknowledge
        ack(v);
        check("R11", v, 32'd0);
        rd(3'd3, v);
        check("R11", v, 32'd0);

        // R2 masked pending source raises nothing
        pulse(26'(1) << 7);
        check("R2", {24'd0, irq_lines}, 32'd0);
        ack(v);
        check("R11", v, 32'd0);
        wr(3'd1, 32'(1) << 7);

        // R3 pulse sets, write clears, simultaneous set wins
        pulse(26'(1) << 6);
        rd(3'd1, v);
        check("R3", v, 32'(1) << 6);
        @(negedge clk);
        src_pulse = 26'(1) << 5;
        reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = (32'(1) << 5) | (32'(1) << 6);
        @(negedge clk);
        src_pulse = '0; reg_we = 1'b0;
        rd(3'd1, v);
        check("R3", v, 32'(1) << 5);
        wr(3'd1, 32'(1) << 5);
        rd(3'd1, v);
        check("R3", v, 32'd0);

        // R2 level sweep with one eligible source
        wr(3'd2, 32'(1) << 0);
        pulse(26'(1));
        for (int l = 0; l < 8; l++) begin
            wr(3'd0, 32'(l));
            check("R2", {24'd0, irq_lines}, 32'(1) << l);
        end

        // R4 acknowledge bit visible for one cycle, vector latched
        wr(3'd4, 32'h1);
        rd(3'd4, v);
        check("R4", {31'd0, v[0]}, 32'd1);
        @(negedge clk);
        rd(3'd4, v);
        check("R4", v, 32'h10);
        wr(3'd1, 32'h1);
        wr(3'd3, 32'h1);
        wr(3'd0, 32'd0);

        // R9 / R10 nesting
        wr(3'd2, {6'd0, {N{1'b1}}});
        pulse(26'(1) << 10);
        ack(v);
        check("R9", {27'd0, v[8:4]}, 32'd11);
        check("R9", {24'd0, irq_lines}, 32'd0);
        pulse(26'(1) << 12);
        check("R9", {24'd0, irq_lines}, 32'd0);
        ack(v);
        check("R9", v, 32'd0);
        pulse(26'(1) << 3);
        check("R9", {24'd0, irq_lines}, 32'd1);
        ack(v);
        check("R9", {27'd0, v[8:4]}, 32'd4);
        rd(3'd3, v);
        check("R9", v, (32'(1) << 3) | (32'(1) << 10));
        wr(3'd3, 32'(1) << 3);
        check("R10", {24'd0, irq_lines}, 32'd1);
        wr(3'd1, 32'(1) << 3);
        check("R10", {24'd0, irq_lines}, 32'd0);
        wr(3'd3, 32'(1) << 10);
        check("R10", {24'd0, irq_lines}, 32'd1);
        ack(v);
        check("R10", {27'd0, v[8:4]}, 32'd11);
        wr(3'd1, {6'd0, {N{1'b1}}});
        wr(3'd3, {6'd0, {N{1'b1}}});

        // R5 default order, R7 grouped rotations, R8 spread rotations
        drain(1'b0, 0, 1'b0, 0, "R5");
        for (int r = 1; r < 4; r++) drain(1'b0, r, 1'b0, 0, "R7");
        for (int r = 0; r < 4; r++) drain(1'b1, r, 1'b0, 0, "R8");

        // R6 promotion of each source, and an out-of-range index
        for (int t = 0; t < N; t++) drain(t[0], t % 4, 1'b1, t, "R6");
        drain(1'b0, 0, 1'b1, 30, "R6");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule